// File: doc/BRIEF.md
# Set/Clear Masked Interrupt Controller

This block gathers five interrupt sources behind a single register address and drives one active-low interrupt request line. Four sources arrive as single-cycle event pulses: timer A, timer B, the event-counter alarm and the serial shifter. The fifth comes from a pin whose falling edge the block detects itself. Each event sets a sticky pending flag. A read of the register returns the flags together with a summary bit, and the same read clears all of them.

A write does not touch the flags. It edits the enable mask instead. The top data bit chooses whether the write sets or clears mask bits. Each low data bit that is 1 selects a mask bit to change, and each low data bit that is 0 leaves its mask bit as it was. The summary bit, and the low level on the request line, follow from any pending flag whose mask bit is set. A host therefore enables the sources it cares about, waits for the request line to fall, and reads the register once to learn the cause and to acknowledge it.

Top module: `isc_ctrl`

## Requirements
- R1: After reset, all flags and all mask bits are 0, `rd_data` reads 0x00 and `irq_n` is 1.
- R2: A one-cycle pulse on a source input sets its pending flag at the next clock edge. The flag positions in `rd_data` are: bit 0 timer A, bit 1 timer B, bit 2 alarm, bit 3 serial, bit 4 edge pin. A set flag stays set until a read.
- R3: The edge-pin flag (bit 4) is set only when `flag_pin_n` goes from 1 to 0, with both levels sampled on the clock. A pin held low or rising from 0 to 1 sets nothing. The pin is taken as high during reset.
- R4: Bits 6 and 5 of `rd_data` always read 0.
- R5: `rd_data` shows the register in the read cycle. A read (`rd_en` high at a clock edge) clears every flag and the summary bit 7 at that edge.
- R6: A write (`wr_en` high) with `wr_data[7]`=1 sets each mask bit whose matching bit in `wr_data[4:0]` is 1.
- R7: A write with `wr_data[7]`=0 clears each mask bit whose matching bit in `wr_data[4:0]` is 1. Mask bits written as 0 keep their value, and the mask holds when no write happens.
- R8: `rd_data[7]` is 1 and `irq_n` is 0 exactly when some pending flag has its mask bit set. A clearing read returns `irq_n` to 1.
- R9: A source event in the same cycle as a read is pending after that read's clear.
- R10: Masked events are still captured. Enabling the mask of a pending flag makes `irq_n` fall right after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_en | input | 1 | Register read strobe; clears flags at the edge |
| wr_en | input | 1 | Register write strobe; updates the mask |
| wr_data | input | 8 | Write data: bit 7 selects set or clear, bits 4:0 select mask bits |
| ev_tmr_a | input | 1 | Timer A underflow pulse |
| ev_tmr_b | input | 1 | Timer B underflow pulse |
| ev_alarm | input | 1 | Event alarm match pulse |
| ev_serial | input | 1 | Serial shifter full/empty pulse |
| flag_pin_n | input | 1 | Edge pin; a falling edge raises flag bit 4 |
| rd_data | output | 8 | Summary bit, zero pad bits and pending flags |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
A flag stuck at 1 appears in `rd_data` in the cycle right after the read that should have cleared it. A flag that gets lost shows as a missing bit one edge after its event, whether the event came alone or during a read. The mask cannot be read back, so a wrong mask bit appears only through `rd_data[7]` and `irq_n`. The bench exposes it by raising the flag and comparing the request line on the next cycle. An edge detector whose history is wrong either misses a real falling edge or sets bit 4 while the pin is held low, and that difference is visible one edge after the pin change.

// File: rtl/isc_pkg.sv
package isc_pkg;
  localparam int SRC_N  = 5;
  localparam int REG_W  = 8;
  localparam int SC_BIT = REG_W - 1;

  // Flag bit positions
  localparam int B_TMR_A  = 0;
  localparam int B_TMR_B  = 1;
  localparam int B_ALARM  = 2;
  localparam int B_SERIAL = 3;
  localparam int B_EDGE   = 4;

  // Next mask after a set/clear write
  function automatic logic [SRC_N-1:0] f_mask_next(
    input logic [SRC_N-1:0] cur,
    input logic             set_sel,
    input logic [SRC_N-1:0] sel
  );
    if (set_sel) return cur | sel;
    else         return cur & ~sel;
  endfunction

  // Next pending flags: optional clear, then new events merged in
  function automatic logic [SRC_N-1:0] f_pend_next(
    input logic [SRC_N-1:0] cur,
    input logic             clr,
    input logic [SRC_N-1:0] ev
  );
    logic [SRC_N-1:0] base;
    base = clr ? '0 : cur;
    return base | ev;
  endfunction
endpackage

// File: rtl/isc_fall_detect.sv
module isc_fall_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  output logic fall
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= pin_n;
  end

  assign fall = prev_q & ~pin_n;
endmodule

// File: rtl/isc_pend_reg.sv
module isc_pend_reg
  import isc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [SRC_N-1:0] ev,
  output logic [SRC_N-1:0] pend
);
  always_ff @(posedge clk) begin
    if (!rst_n) pend <= '0;
    else        pend <= f_pend_next(pend, clr, ev);
  end
endmodule

// File: rtl/isc_mask_reg.sv
module isc_mask_reg
  import isc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [SRC_N-1:0] mask
);
  logic unused_pad;
  assign unused_pad = ^wr_data[SC_BIT-1:SRC_N];

  always_ff @(posedge clk) begin
    if (!rst_n)     mask <= '0;
    else if (wr_en) mask <= f_mask_next(mask, wr_data[SC_BIT], wr_data[SRC_N-1:0]);
  end
endmodule

// File: rtl/isc_ctrl.sv
module isc_ctrl
  import isc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_en,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             ev_tmr_a,
  input  logic             ev_tmr_b,
  input  logic             ev_alarm,
  input  logic             ev_serial,
  input  logic             flag_pin_n,
  output logic [REG_W-1:0] rd_data,
  output logic             irq_n
);
  // Named internal events for the checker
  logic             flag_fall;
  logic [SRC_N-1:0] src_ev;
  logic [SRC_N-1:0] pend_q;
  logic [SRC_N-1:0] mask_q;
  logic             ir;

  isc_fall_detect u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .pin_n (flag_pin_n),
    .fall  (flag_fall)
  );

  always_comb begin
    src_ev           = '0;
    src_ev[B_TMR_A]  = ev_tmr_a;
    src_ev[B_TMR_B]  = ev_tmr_b;
    src_ev[B_ALARM]  = ev_alarm;
    src_ev[B_SERIAL] = ev_serial;
    src_ev[B_EDGE]   = flag_fall;
  end

  isc_pend_reg u_pend (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (rd_en),
    .ev    (src_ev),
    .pend  (pend_q)
  );

  isc_mask_reg u_mask (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .mask    (mask_q)
  );

  assign ir    = |(pend_q & mask_q);
  assign irq_n = ~ir;

  for (genvar g = 0; g < REG_W; g++) begin : g_rd
    if (g < SRC_N) begin : g_flag
      assign rd_data[g] = pend_q[g];
    end else if (g == SC_BIT) begin : g_sum
      assign rd_data[g] = ir;
    end else begin : g_pad
      assign rd_data[g] = 1'b0;
    end
  end
endmodule

// File: rtl/isc_ctrl_chk.sv
module isc_ctrl_chk
  import isc_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             rd_en,
  input logic             wr_en,
  input logic [REG_W-1:0] wr_data,
  input logic             ev_tmr_a,
  input logic             flag_fall,
  input logic [SRC_N-1:0] src_ev,
  input logic [SRC_N-1:0] mask_q,
  input logic [REG_W-1:0] rd_data,
  input logic             irq_n
);
  p_pad_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[SC_BIT-1:SRC_N] == '0);

  p_sum_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[SC_BIT] == |(rd_data[SRC_N-1:0] & mask_q)) && (irq_n == !rd_data[SC_BIT]));

  p_read_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && src_ev == '0) |=> (rd_data == '0 && irq_n));

  p_keep_event_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && ev_tmr_a) |=> rd_data[B_TMR_A]);

  p_edge_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    flag_fall |=> rd_data[B_EDGE]);

  p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> (($past(rd_data[SRC_N-1:0]) & ~rd_data[SRC_N-1:0]) == '0));

  p_mask_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[SC_BIT]) |=>
      ((mask_q & $past(wr_data[SRC_N-1:0])) == $past(wr_data[SRC_N-1:0])));

  p_mask_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_data[SC_BIT]) |=> ((mask_q & $past(wr_data[SRC_N-1:0])) == '0));

  p_mask_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(mask_q));
endmodule

bind isc_ctrl isc_ctrl_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rd_en     (rd_en),
  .wr_en     (wr_en),
  .wr_data   (wr_data),
  .ev_tmr_a  (ev_tmr_a),
  .flag_fall (flag_fall),
  .src_ev    (src_ev),
  .mask_q    (mask_q),
  .rd_data   (rd_data),
  .irq_n     (irq_n)
);

// File: tb/test_isc_ctrl.sv
module test_isc_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rd_en = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       ev_tmr_a = 1'b0, ev_tmr_b = 1'b0, ev_alarm = 1'b0, ev_serial = 1'b0;
  logic       flag_pin_n = 1'b1;
  logic [7:0] rd_data;
  logic       irq_n;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    string      tag;
    logic [7:0] rd;
    logic       irq;
  } exp_t;
  exp_t sb[$];

  // Bench model of the requirements
  logic [4:0] m_pend = '0;
  logic [4:0] m_mask = '0;
  logic       m_pin_prev = 1'b1;

  isc_ctrl i_isc_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_en      (rd_en),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .ev_tmr_a   (ev_tmr_a),
    .ev_tmr_b   (ev_tmr_b),
    .ev_alarm   (ev_alarm),
    .ev_serial  (ev_serial),
    .flag_pin_n (flag_pin_n),
    .rd_data    (rd_data),
    .irq_n      (irq_n)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Driver: one cycle of stimulus plus its expected result after the edge
  task automatic step(input bit rd, input bit wr, input logic [7:0] d,
                      input logic [3:0] ev, input bit pin, input string tag);
    exp_t e;
    logic pending_any;
    @(negedge clk);
    rd_en = rd; wr_en = wr; wr_data = d;
    ev_tmr_a = ev[0]; ev_tmr_b = ev[1]; ev_alarm = ev[2]; ev_serial = ev[3];
    flag_pin_n = pin;
    // R2/R3/R5/R9: flags after this edge
    if (rd) m_pend = '0;
    m_pend = m_pend | {(m_pin_prev == 1'b1 && pin == 1'b0), ev};
    m_pin_prev = pin;
    // R6/R7: mask after this edge
    if (wr) begin
      for (int i = 0; i < 5; i++)
        if (d[i]) m_mask[i] = d[7];
    end
    pending_any = 1'b0;
    for (int i = 0; i < 5; i++)
      if (m_pend[i] && m_mask[i]) pending_any = 1'b1;
    e.tag = tag;
    e.rd  = {pending_any, 2'b00, m_pend};
    e.irq = !pending_any;
    sb.push_back(e);
  endtask

  task automatic idle(input string tag);
    step(1'b0, 1'b0, 8'h00, 4'h0, m_pin_prev, tag);
  endtask

  // Monitor: compare after each edge
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #(CLK_PERIOD/4);
      if (sb.size() > 0) begin
        e = sb.pop_front();
        checks++;
        if (rd_data !== e.rd || irq_n !== e.irq) begin
          errors++;
          $display("FAIL %s rd_data=%h irq_n=%b expected rd_data=%h irq_n=%b",
                   e.tag, rd_data, irq_n, e.rd, e.irq);
        end
      end
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    idle("R1 reset state");
    // R2 + R10: each timed source alone, captured while masked
    for (int k = 0; k < 4; k++) begin
      step(1'b0, 1'b0, 8'h00, 4'(1 << k), 1'b1, "R2 R10 source capture masked");
      idle("R2 flag sticky");
      step(1'b1, 1'b0, 8'h00, 4'h0, 1'b1, "R5 read clears");
    end
    // R3: edge pin
    step(1'b0, 1'b0, 8'h00, 4'h0, 1'b0, "R3 falling edge sets bit4");
    step(1'b1, 1'b0, 8'h00, 4'h0, 1'b0, "R5 read clears edge flag");
    idle("R3 held low sets nothing");
    step(1'b0, 1'b0, 8'h00, 4'h0, 1'b1, "R3 rising edge sets nothing");
    step(1'b0, 1'b0, 8'h00, 4'h0, 1'b0, "R3 second falling edge");
    step(1'b1, 1'b0, 8'h00, 4'h0, 1'b0, "R5 clear");
    // R4: all sources together
    step(1'b0, 1'b0, 8'h00, 4'hF, 1'b1, "R4 pad bits zero, all sources");
    step(1'b0, 1'b0, 8'h00, 4'h0, 1'b0, "R4 R2 edge with others pending");
    step(1'b1, 1'b0, 8'h00, 4'h0, 1'b0, "R5 clear all");
    // R6/R8: enable timer A, fire it
    step(1'b0, 1'b1, 8'h81, 4'h0, 1'b0, "R6 set timer A mask");
    step(1'b0, 1'b0, 8'h00, 4'h1, 1'b0, "R8 enabled source drives irq");
    idle("R8 irq held");
    step(1'b1, 1'b0, 8'h00, 4'h0, 1'b0, "R8 read releases irq");
    // R10: masked serial pending, enable later
    step(1'b0, 1'b0, 8'h00, 4'h8, 1'b0, "R10 masked serial no irq");
    step(1'b0, 1'b1, 8'h88, 4'h0, 1'b0, "R10 enabling pending raises irq");
    // R7: clear serial mask only, timer A mask stays
    step(1'b0, 1'b1, 8'h08, 4'h0, 1'b0, "R7 clear serial mask");
    step(1'b0, 1'b0, 8'h00, 4'h1, 1'b0, "R7 zero bits keep timer A mask");
    step(1'b0, 1'b1, 8'h80, 4'h0, 1'b0, "R7 set with no bits changes nothing");
    step(1'b0, 1'b1, 8'h00, 4'h0, 1'b0, "R7 clear with no bits changes nothing");
    step(1'b1, 1'b0, 8'h00, 4'h0, 1'b0, "R5 clear");
    // R9: event during read survives
    step(1'b0, 1'b0, 8'h00, 4'h2, 1'b0, "R9 timer B pending");
    step(1'b1, 1'b0, 8'h00, 4'h1, 1'b0, "R9 timer A during read kept, irq");
    step(1'b1, 1'b0, 8'h00, 4'h0, 1'b1, "R9 R5 read clears survivor");
    // Read and write together, plus edge during read
    step(1'b1, 1'b1, 8'h90, 4'h0, 1'b0, "R9 R6 edge during read with mask write");
    idle("R8 edge flag enabled irq");
    step(1'b0, 1'b1, 8'h1F, 4'h0, 1'b0, "R7 clear all masks drops irq");
    step(1'b1, 1'b0, 8'h00, 4'h0, 1'b0, "R5 final clear");
    idle("R1 quiet end");
    repeat (3) @(posedge clk);
    #(CLK_PERIOD/2);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule